// File: doc/BRIEF.md
# Receive Frame Tag Capture

This block collects a short user-supplied tag for each received frame through a two-wire synchronous port. The port has a serial data bit and a data enable, and both are sampled on the rising edge of the receive clock. An external start-of-data strobe arms the capture. After that, each cycle with the enable high shifts one bit into a tag register, most significant bit first. The capture closes when the receive-data-valid input drops.

At that point the tag is copied into a holding register and announced with a one-cycle valid pulse. The tag is reported as zero unless two configuration enables are both set. These are the interface-select bit and the tag-feature bit. Between frames the shift register returns to zero, so a tag shorter than the register width leaves the upper bits at zero.

If the enable is still high when the frame has already ended, that bit is ignored and an error flag is raised for the frame.

Top module: `rxtag_capture`

## Requirements
- R1: The tag register is TAG_W bits wide (default 15). Each accepted bit shifts the contents left by one and enters at bit 0, so a tag of n < TAG_W bits appears in bits n-1..0 with the upper bits zero.
- R2: A bit is accepted only in a cycle where the block is armed, `rx_dv` is 1 and `tag_en` is 1. A cycle with `tag_en` at 0 leaves the register unchanged.
- R3: When more than TAG_W bits arrive in one frame, the oldest bits are dropped off the top. The result is the last TAG_W bits received.
- R4: The block arms in the cycle after `sod_strb` is sampled 1 while `rx_dv` is 1. Bits offered before that point, including the strobe cycle itself, are ignored. A strobe while `rx_dv` is 0 does not arm, and a frame that never arms reports zero.
- R5: A frame ends in the first cycle where `rx_dv` is sampled 0 after being 1. On that edge, `tag_valid` goes high for exactly one cycle and `tag_word` takes the new value. `tag_word` then holds until the next frame end.
- R6: The shift register is cleared at every frame end, so each frame's tag is built from zero.
- R7: `tag_word` is loaded with zero unless `cfg_if_sel` and `cfg_tag_on` are both 1 in the frame-end cycle.
- R8: If `tag_en` is 1 in the frame-end cycle, that bit is not taken. `tag_err` is set together with `tag_valid` and holds until the next frame end. Enables in the idle cycles after the frame are ignored.
- R9: After reset, `tag_word`, `tag_valid` and `tag_err` are 0.
- R10: Further `sod_strb` pulses while the block is armed do not change the capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_dv | input | 1 | Receive data valid; high for the length of a frame |
| sod_strb | input | 1 | Start-of-data strobe from the framing logic |
| tag_dat | input | 1 | Serial tag data bit |
| tag_en | input | 1 | Tag data enable; one bit is shifted per cycle it is high |
| cfg_if_sel | input | 1 | Interface-select enable; must be 1 for the tag to be reported |
| cfg_tag_on | input | 1 | Tag-feature enable; must be 1 for the tag to be reported |
| tag_word | output | TAG_W | Tag captured in the last frame (zero when gated off) |
| tag_valid | output | 1 | One-cycle pulse when `tag_word` is updated |
| tag_err | output | 1 | Enable was still high at frame end in the last frame |

## Verification
The bench builds the block with TAG_W = 5. This brings the overflow boundary within reach of short frames. Every bit pattern of 0 to 7 bits is swept through the port, so it covers tags shorter than, equal to and longer than the register. The sweep mixes gap cycles, trailing enables and extra strobes. Separate frames cover all four combinations of the two enables, frames that never arm, a strobe given outside a frame, and a short tag that follows a full one.

// File: rtl/rxtag_pkg.sv
// Package: shared types and helpers for the receive tag capture block.
// Assumes a single clock domain (the receive clock).
package rxtag_pkg;

    // Capture state: waiting for the start-of-data strobe, or shifting.
    typedef enum logic {
        TS_IDLE  = 1'b0,
        TS_ARMED = 1'b1
    } tag_state_e;

    // The tag is reported only when both configuration enables are set.
    function automatic logic report_allowed(input logic if_sel, input logic tag_on);
        return if_sel & tag_on;
    endfunction

endpackage

// File: rtl/rxtag_frame_ctl.sv
// Module: rxtag_frame_ctl
// Arms the capture on the start-of-data strobe within a frame. It disarms
// when rx_dv drops, marks the frame-end cycle, and qualifies shift cycles.
// Assumes rx_dv is held high for the whole frame and the strobe is synchronous.
module rxtag_frame_ctl
    import rxtag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_dv,
    input  logic sod_strb,
    input  logic tag_en,
    output logic armed,
    output logic frame_end,
    output logic shift_go
);

    tag_state_e st_q;
    tag_state_e st_d;
    logic       dv_q;

    // Next-state logic: arm on strobe inside a frame, drop back when rx_dv falls.
    always_comb begin
        st_d = st_q;
        case (st_q)
            TS_IDLE:  if (rx_dv && sod_strb) st_d = TS_ARMED;
            TS_ARMED: if (!rx_dv)            st_d = TS_IDLE;
            default:                         st_d = TS_IDLE;
        endcase
    end

    // State and delayed rx_dv registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= TS_IDLE;
            dv_q <= 1'b0;
        end else begin
            st_q <= st_d;
            dv_q <= rx_dv;
        end
    end

    assign armed     = (st_q == TS_ARMED);
    assign frame_end = dv_q & ~rx_dv;
    assign shift_go  = armed & rx_dv & tag_en;

endmodule

// File: rtl/rxtag_shifter.sv
// Module: rxtag_shifter
// TAG_W-bit left shift register, most significant bit first, with a clear.
// Assumes clear and shift are never requested in the same cycle. Clear wins
// if they are.
module rxtag_shifter #(
    parameter int TAG_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_go,
    input  logic             bit_in,
    output logic [TAG_W-1:0] q
);

    generate
        if (TAG_W == 1) begin : g_single
            // Single-bit register: the newest bit replaces the old one.
            always_ff @(posedge clk) begin
                if (!rst_n || clear) q <= '0;
                else if (shift_go)   q <= bit_in;
            end
        end else begin : g_multi
            // Shift left, new bit enters at bit 0, oldest bit falls off the top.
            always_ff @(posedge clk) begin
                if (!rst_n || clear) q <= '0;
                else if (shift_go)   q <= {q[TAG_W-2:0], bit_in};
            end
        end
    endgenerate

endmodule

// File: rtl/rxtag_report.sv
// Module: rxtag_report
// At frame end, loads the gated tag and the late-enable flag into holding
// registers and pulses valid for one cycle.
// Assumes frame_end is a single-cycle strobe.
module rxtag_report
    import rxtag_pkg::*;
#(
    parameter int TAG_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_end,
    input  logic [TAG_W-1:0] shreg,
    input  logic             cfg_if_sel,
    input  logic             cfg_tag_on,
    input  logic             late_en,
    output logic [TAG_W-1:0] tag_word,
    output logic             tag_valid,
    output logic             tag_err
);

    // Holding registers: updated only at frame end, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_word <= '0;
            tag_err  <= 1'b0;
        end else if (frame_end) begin
            tag_word <= report_allowed(cfg_if_sel, cfg_tag_on) ? shreg : '0;
            tag_err  <= late_en;
        end
    end

    // Valid pulse: one cycle after each frame-end edge.
    always_ff @(posedge clk) begin
        if (!rst_n) tag_valid <= 1'b0;
        else        tag_valid <= frame_end;
    end

endmodule

// File: rtl/rxtag_capture.sv
// Module: rxtag_capture (top)
// Receive frame tag capture. A two-wire serial port (data and enable) on the
// receive clock is armed by the start-of-data strobe. The tag is shifted in
// most significant bit first and closed when rx_dv drops, then reported gated
// by two enables.
// Assumes all inputs are synchronous to clk.
module rxtag_capture #(
    parameter int TAG_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_dv,
    input  logic             sod_strb,
    input  logic             tag_dat,
    input  logic             tag_en,
    input  logic             cfg_if_sel,
    input  logic             cfg_tag_on,
    output logic [TAG_W-1:0] tag_word,
    output logic             tag_valid,
    output logic             tag_err
);

    logic             armed;
    logic             frame_end;
    logic             shift_go;
    logic [TAG_W-1:0] shreg;

    rxtag_frame_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_dv     (rx_dv),
        .sod_strb  (sod_strb),
        .tag_en    (tag_en),
        .armed     (armed),
        .frame_end (frame_end),
        .shift_go  (shift_go)
    );

    rxtag_shifter #(.TAG_W(TAG_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (frame_end),
        .shift_go (shift_go),
        .bit_in   (tag_dat),
        .q        (shreg)
    );

    rxtag_report #(.TAG_W(TAG_W)) u_rep (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_end  (frame_end),
        .shreg      (shreg),
        .cfg_if_sel (cfg_if_sel),
        .cfg_tag_on (cfg_tag_on),
        .late_en    (tag_en),
        .tag_word   (tag_word),
        .tag_valid  (tag_valid),
        .tag_err    (tag_err)
    );

endmodule

// File: rtl/rxtag_capture_chk.sv
// Module: rxtag_capture_chk
// Property checker for rxtag_capture, attached by bind. It keeps its own
// copies of rx_dv, the enable gate and the late enable to relate outputs to
// inputs.
module rxtag_capture_chk #(
    parameter int TAG_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_dv,
    input logic             sod_strb,
    input logic             tag_dat,
    input logic             tag_en,
    input logic             cfg_if_sel,
    input logic             cfg_tag_on,
    input logic [TAG_W-1:0] tag_word,
    input logic             tag_valid,
    input logic             tag_err,
    input logic             armed,
    input logic [TAG_W-1:0] shreg
);

    logic prev_dv;
    logic gate_q;
    logic en_q;

    // Checker-side history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_dv <= 1'b0;
            gate_q  <= 1'b0;
            en_q    <= 1'b0;
        end else begin
            prev_dv <= rx_dv;
            gate_q  <= cfg_if_sel & cfg_tag_on;
            en_q    <= tag_en;
        end
    end

    a_r2_shift_bit: assert property (@(posedge clk) disable iff (!rst_n)
        armed && rx_dv && tag_en |=> shreg[0] == $past(tag_dat));

    a_r2_hold_no_en: assert property (@(posedge clk) disable iff (!rst_n)
        armed && rx_dv && !tag_en |=> $stable(shreg));

    a_r4_arm_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(sod_strb && rx_dv));

    a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> shreg == '0);

    a_r5_valid_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        prev_dv && !rx_dv |=> tag_valid);

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid |=> !tag_valid);

    a_r5_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        !tag_valid |-> $stable(tag_word));

    a_r7_gated_zero: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid && !gate_q |-> tag_word == '0);

    a_r8_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid |-> tag_err == en_q);

endmodule

bind rxtag_capture rxtag_capture_chk #(.TAG_W(TAG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_dv      (rx_dv),
    .sod_strb   (sod_strb),
    .tag_dat    (tag_dat),
    .tag_en     (tag_en),
    .cfg_if_sel (cfg_if_sel),
    .cfg_tag_on (cfg_tag_on),
    .tag_word   (tag_word),
    .tag_valid  (tag_valid),
    .tag_err    (tag_err),
    .armed      (armed),
    .shreg      (shreg)
);

// File: tb/rxtag_capture_tb.sv
// Bench for rxtag_capture: sweeps every tag pattern of 0..7 bits through a
// 5-bit instance, plus targeted frames for arming, gating and clearing.
module rxtag_capture_tb;

    localparam int TAG_W      = 5;
    localparam int CLK_PERIOD = 10;
    localparam int MASK       = (1 << TAG_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             rx_dv, sod_strb, tag_dat, tag_en, cfg_if_sel, cfg_tag_on;
    logic [TAG_W-1:0] tag_word;
    logic             tag_valid, tag_err;

    int n_checks = 0;
    int n_err    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxtag_capture #(.TAG_W(TAG_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .sod_strb(sod_strb),
        .tag_dat(tag_dat), .tag_en(tag_en), .cfg_if_sel(cfg_if_sel),
        .cfg_tag_on(cfg_tag_on), .tag_word(tag_word), .tag_valid(tag_valid),
        .tag_err(tag_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drives one frame, then checks the report. n bits of pat, MSB first.
    task automatic frame(input int n, input int pat, input bit gaps, input bit sel,
                         input bit fen, input bit late, input bit strobe,
                         input string req);
        int exp = 0;
        for (int i = 0; i < n; i++)
            if (strobe) exp = ((exp << 1) | ((pat >> (n - 1 - i)) & 1)) & MASK;
        if (!(sel && fen)) exp = 0;
        cfg_if_sel = sel; cfg_tag_on = fen;
        // Preamble: junk enables before the strobe are ignored (R4).
        rx_dv = 1'b1; sod_strb = 1'b0; tag_en = 1'b1; tag_dat = 1'b1;
        repeat (2) @(negedge clk);
        // Strobe cycle; its own enable is ignored (R4).
        sod_strb = strobe;
        @(negedge clk);
        sod_strb = 1'b0;
        for (int i = 0; i < n; i++) begin
            tag_en   = 1'b1;
            tag_dat  = ((pat >> (n - 1 - i)) & 1) != 0;
            sod_strb = strobe && (i % 3 == 2);   // extra strobes (R10)
            @(negedge clk);
            sod_strb = 1'b0;
            if (gaps) begin
                tag_en = 1'b0; tag_dat = 1'b1;   // idle gap cycle (R2)
                @(negedge clk);
            end
        end
        if (n == 0) tag_en = 1'b0;
        if (n == 0) @(negedge clk);
        // Frame end; a late enable carries a 1 that must not enter (R8).
        rx_dv = 1'b0; tag_en = late; tag_dat = 1'b1;
        @(negedge clk);
        chk(tag_valid == 1'b1, "R5", "valid at frame end", int'(tag_valid), 1);
        chk(int'(tag_word) == exp, req, "tag word", int'(tag_word), exp);
        chk(tag_err == late, "R8", "error flag", int'(tag_err), int'(late));
        // Enable after the frame: ignored, output held (R5/R8).
        tag_en = 1'b1;
        @(negedge clk);
        chk(tag_valid == 1'b0, "R5", "single pulse", int'(tag_valid), 0);
        chk(int'(tag_word) == exp, "R5", "word held", int'(tag_word), exp);
        tag_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rx_dv = 1'b0; sod_strb = 1'b0; tag_dat = 1'b0; tag_en = 1'b0;
        cfg_if_sel = 1'b1; cfg_tag_on = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(tag_word == '0, "R9", "reset word", int'(tag_word), 0);
        chk(tag_valid == 1'b0, "R9", "reset valid", int'(tag_valid), 0);
        chk(tag_err == 1'b0, "R9", "reset err", int'(tag_err), 0);

        // R1/R3 sweep: all patterns of 0..7 bits, with varied gaps and late enables.
        for (int n = 0; n <= 7; n++)
            for (int p = 0; p < (1 << n); p++)
                frame(n, p, ((p ^ n) & 1) != 0, 1'b1, 1'b1, (p % 3) == 1, 1'b1,
                      (n > TAG_W) ? "R3" : "R1");

        // R7: every enable combination with a full tag.
        for (int g = 0; g < 4; g++)
            frame(TAG_W, 5'b10110, 1'b0, g[0], g[1], 1'b0, 1'b1, "R7");

        // R4: no strobe in the frame, so the tag reads zero.
        frame(4, 4'b1111, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R4");
        // R4: a strobe outside the frame does not arm the next frame.
        sod_strb = 1'b1; @(negedge clk); sod_strb = 1'b0;
        frame(3, 3'b111, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R4");

        // R6: a full tag, then a short one, must not inherit the upper bits.
        frame(TAG_W, 5'b11111, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R6");
        frame(1, 1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R6");
        frame(0, 0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R6");

        // R2/R10: gaps and extra strobes on a long frame.
        frame(7, 7'b1010011, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R10");
        frame(6, 6'b011101, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R2");

        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule